// File: doc/BRIEF.md
# Byte-Wide Link Port Packer

This block is one end of a point-to-point link that moves data eight bits at a time between two devices. The core side uses word-wide valid/ready streams. The link side uses three signals in each direction: a byte bus, a strobe and an acknowledge. The strobe marks every cycle in which a byte is on the bus. The acknowledge comes back from the receiver and tells the sender whether it may begin another word. A word is either 32 bits long (four bytes) or 48 bits long (six bytes), and the least significant byte always travels first.

A direction bit makes the port either a transmitter or a receiver. As a transmitter, the port takes words from the core into a holding register, moves each one into a shift register and sends it out byte by byte. As a receiver, the port assembles incoming bytes into a word and then passes the word to a holding register that faces the core. Each direction therefore has two word stores. While one word crosses the link, the next one waits.

Direction and word size are sampled only while the port is disabled. Disabling the port empties both stores and resets the byte position.

Top module: `link_pack`

## Requirements
- R1: In transmit mode, `lnk_clk_o` is high for exactly those cycles that carry a byte, one byte per high cycle. `lnk_dout` reads zero whenever `lnk_clk_o` is low.
- R2: Words cross the link least significant byte first. With `wide`=0 a word is 4 bytes and bits 47:32 of `rx_word` read zero. With `wide`=1 a word is 6 bytes.
- R3: In receive mode, `lnk_ack_o` is high except while a completed word waits in the holding register and a second completed word waits in the assembly register. While both are full, strobed bytes are discarded.
- R4: A word moves across the core interface only in a cycle where valid and ready are both high. `rx_word` holds steady while `rx_valid` is high and `rx_ready` is low.
- R5: The transmitter puts the first byte of a word on the link only in a cycle where `lnk_ack_i` is high. The remaining bytes of that word follow on consecutive cycles whatever `lnk_ack_i` does.
- R6: The transmitter accepts a second word from the core while the first word is still being sent. With `lnk_ack_i` held high, back-to-back words leave no idle link cycle between them.
- R7: `dir_tx`=1 selects transmit, in which `lnk_ack_o` and `rx_valid` stay low. `dir_tx`=0 selects receive, in which `tx_ready` and `lnk_clk_o` stay low.
- R8: `dir_tx` and `wide` are sampled only while `enable` is low. Changing them while the port is enabled has no effect.
- R9: After reset, or one clock edge after `enable` is low, both word stores are empty, a partly assembled word is discarded and the byte position restarts at zero. While `enable` is low, `tx_ready`, `lnk_clk_o` and `lnk_ack_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Port enable; low clears the port and lets the mode be set |
| dir_tx | input | 1 | 1 = transmitter, 0 = receiver (sampled while disabled) |
| wide | input | 1 | 1 = 48-bit words, 0 = 32-bit words (sampled while disabled) |
| tx_word | input | 48 | Word offered by the core for sending |
| tx_valid | input | 1 | `tx_word` is valid |
| tx_ready | output | 1 | Transmit holding register can take a word |
| rx_word | output | 48 | Received word |
| rx_valid | output | 1 | `rx_word` is valid |
| rx_ready | input | 1 | Core takes `rx_word` |
| lnk_dout | output | 8 | Outgoing link byte |
| lnk_clk_o | output | 1 | Outgoing byte strobe |
| lnk_ack_i | input | 1 | Acknowledge from the far receiver |
| lnk_din | input | 8 | Incoming link byte |
| lnk_clk_i | input | 1 | Incoming byte strobe |
| lnk_ack_o | output | 1 | Acknowledge to the far transmitter |

## Verification
A byte counter that drifts shows up at the first word after the fault as bytes at the wrong positions, or as a word that closes after the wrong number of bytes. A lost full flag shows up as a duplicated or missing word on the core side. The sweeps compare every reassembled word against its arithmetic value, so these faults are caught within one word time. A wrong full flag in the receiver shows at `lnk_ack_o` in the cycle after the second word completes. A mode or clear fault shows in the first cycle after enable changes.

// File: rtl/link_pack.sv
module link_pack #(
  parameter int BYTE_W       = 8,
  parameter int NARROW_BYTES = 4,
  parameter int WIDE_BYTES   = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         enable,
  input  logic                         dir_tx,
  input  logic                         wide,
  input  logic [BYTE_W*WIDE_BYTES-1:0] tx_word,
  input  logic                         tx_valid,
  output logic                         tx_ready,
  output logic [BYTE_W*WIDE_BYTES-1:0] rx_word,
  output logic                         rx_valid,
  input  logic                         rx_ready,
  output logic [BYTE_W-1:0]            lnk_dout,
  output logic                         lnk_clk_o,
  input  logic                         lnk_ack_i,
  input  logic [BYTE_W-1:0]            lnk_din,
  input  logic                         lnk_clk_i,
  output logic                         lnk_ack_o
);
  localparam int WORD_W   = BYTE_W * WIDE_BYTES;
  localparam int NARROW_W = BYTE_W * NARROW_BYTES;
  localparam int CNT_W    = $clog2(WIDE_BYTES);
  localparam logic [CNT_W-1:0] LAST_N = CNT_W'(NARROW_BYTES - 1);
  localparam logic [CNT_W-1:0] LAST_W = CNT_W'(WIDE_BYTES - 1);
  localparam logic [WORD_W-1:0] NARROW_MASK = {{(WORD_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic m_tx, m_wide;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_tx   <= 1'b0;
      m_wide <= 1'b0;
    end else if (!enable) begin
      m_tx   <= dir_tx;
      m_wide <= wide;
    end
  end

  wire run_tx = enable & m_tx;
  wire run_rx = enable & ~m_tx;
  wire [CNT_W-1:0]  last_idx  = m_wide ? LAST_W : LAST_N;
  wire [WORD_W-1:0] word_mask = m_wide ? {WORD_W{1'b1}} : NARROW_MASK;

  // transmit path: holding register feeding a byte shifter
  logic [WORD_W-1:0] th, tsh;
  logic              th_full, tsh_busy;
  logic [CNT_W-1:0]  tcnt;

  assign tx_ready  = run_tx & ~th_full;
  assign lnk_clk_o = run_tx & tsh_busy & ((tcnt != '0) | lnk_ack_i);
  assign lnk_dout  = lnk_clk_o ? tsh[BYTE_W-1:0] : '0;

  wire t_take = tx_valid & tx_ready;
  wire t_last = lnk_clk_o & (tcnt == last_idx);
  wire t_load = th_full & (~tsh_busy | t_last);

  always_ff @(posedge clk) begin
    if (!rst_n || !run_tx) begin
      th       <= '0;
      tsh      <= '0;
      th_full  <= 1'b0;
      tsh_busy <= 1'b0;
      tcnt     <= '0;
    end else begin
      if (t_take) begin
        th      <= tx_word & word_mask;
        th_full <= 1'b1;
      end else if (t_load) begin
        th_full <= 1'b0;
      end
      if (t_load) begin
        tsh      <= th;
        tsh_busy <= 1'b1;
        tcnt     <= '0;
      end else if (lnk_clk_o) begin
        tsh <= tsh >> BYTE_W;
        if (t_last) begin
          tsh_busy <= 1'b0;
          tcnt     <= '0;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end

  // receive path: assembly register feeding a holding register
  logic [WORD_W-1:0] asm_q, asm_nx, rh;
  logic              asm_full, rh_full;
  logic [CNT_W-1:0]  rcnt;

  assign lnk_ack_o = run_rx & ~asm_full;
  assign rx_valid  = rh_full;
  assign rx_word   = rh;

  wire r_byte = run_rx & lnk_clk_i & ~asm_full;
  wire r_done = r_byte & (rcnt == last_idx);
  wire r_pop  = rh_full & rx_ready;
  wire r_free = ~rh_full | r_pop;

  always_comb begin
    asm_nx = asm_q;
    asm_nx[rcnt*BYTE_W +: BYTE_W] = lnk_din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run_rx) begin
      asm_q    <= '0;
      rh       <= '0;
      asm_full <= 1'b0;
      rh_full  <= 1'b0;
      rcnt     <= '0;
    end else if (asm_full && r_free) begin
      rh       <= asm_q;
      rh_full  <= 1'b1;
      asm_full <= 1'b0;
      asm_q    <= '0;
    end else if (r_done && r_free) begin
      rh      <= asm_nx;
      rh_full <= 1'b1;
      asm_q   <= '0;
      rcnt    <= '0;
    end else begin
      if (r_pop) rh_full <= 1'b0;
      if (r_byte) begin
        asm_q <= asm_nx;
        if (r_done) begin
          asm_full <= 1'b1;
          rcnt     <= '0;
        end else begin
          rcnt <= rcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/link_pack_chk.sv
module link_pack_chk #(
  parameter int WORD_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              wide,
  input logic              tx_ready,
  input logic [WORD_W-1:0] rx_word,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              lnk_clk_o,
  input logic              lnk_ack_i,
  input logic              lnk_ack_o
);
  logic       c_wide;
  logic [2:0] c_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) c_wide <= 1'b0;
    else if (!enable) c_wide <= wide;
    if (!rst_n || !enable) c_cnt <= '0;
    else if (lnk_clk_o) c_cnt <= (c_cnt == (c_wide ? 3'd5 : 3'd3)) ? 3'd0 : c_cnt + 3'd1;
  end

  a_r5_first_byte_acked: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_clk_o && c_cnt == 3'd0 |-> lnk_ack_i);

  a_r4_rx_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready && enable |=> rx_valid && $stable(rx_word));

  a_r3_ack_drop_means_full: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lnk_ack_o) && enable && $past(enable) |-> rx_valid);

  a_r7_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(lnk_clk_o && lnk_ack_o) && !(tx_ready && (rx_valid || lnk_ack_o)));

  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !tx_ready && !lnk_clk_o && !lnk_ack_o);

  a_r9_disable_empties: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!enable) |-> !rx_valid);
endmodule

bind link_pack link_pack_chk u_chk (.*);

// File: tb/link_pack_tb.sv
module link_pack_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n, enable, dir_tx, wide;
  logic [47:0] tx_word;
  logic        tx_valid, tx_ready;
  logic [47:0] rx_word;
  logic        rx_valid, rx_ready;
  logic [7:0]  lnk_dout, lnk_din;
  logic        lnk_clk_o, lnk_ack_i, lnk_clk_i, lnk_ack_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  link_pack u_dut (.*);

  function automatic logic [47:0] gen(int k, int s);
    return 48'h1F2E_3D4C_5B6A ^ (48'(k) * 48'h0000_0101_0303) ^ (48'(s) << 40) ^ 48'(s * 7);
  endfunction

  function automatic logic [47:0] msk(bit w);
    return w ? 48'hFFFF_FFFF_FFFF : 48'h0000_FFFF_FFFF;
  endfunction

  task automatic chk(bit ok, string req, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic setup(bit d, bit w);
    @(negedge clk);
    enable = 1'b0; dir_tx = d; wide = w;
    tx_valid = 1'b0; rx_ready = 1'b0; lnk_clk_i = 1'b0; lnk_din = '0; lnk_ack_i = 1'b0;
    @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic tx_run(bit w, int ackmode, int n);
    int pi = 0, got = 0, bi = 0, cyc = 0;
    int nb = w ? 6 : 4;
    logic [47:0] acc = '0;
    while (got < n && cyc < 3000) begin
      @(negedge clk);
      tx_valid  = (pi < n);
      tx_word   = gen(pi, ackmode);
      lnk_ack_i = (ackmode == 0) ? 1'b1 : ((cyc % (ackmode + 2)) != 0);
      #1;
      if (tx_valid && tx_ready) pi++;
      if (lnk_clk_o) begin
        if (bi == 0) chk(lnk_ack_i, "R5 first byte without ack", 48'(lnk_ack_i), 48'd1);
        acc[bi*8 +: 8] = lnk_dout;
        bi++;
        if (bi == nb) begin
          chk(acc == (gen(got, ackmode) & msk(w)), "R2 transmitted word", acc, gen(got, ackmode) & msk(w));
          if (got == 0 && ackmode == 0) chk(pi >= 2, "R6 second word taken during first", 48'(pi), 48'd2);
          got++; bi = 0; acc = '0;
        end
      end else begin
        chk(lnk_dout == 8'h00, "R1 idle byte bus", 48'(lnk_dout), 48'd0);
      end
      chk(!lnk_ack_o && !rx_valid, "R7 receive side quiet in transmit", 48'({lnk_ack_o, rx_valid}), 48'd0);
      cyc++;
    end
    chk(got == n, "R4 transmit word count", 48'(got), 48'(n));
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic rx_run(bit w, int pace, int n, int s);
    int bw = 0, bb = 0, ri = 0, cyc = 0;
    int nb = w ? 6 : 4;
    bit snd;
    logic [47:0] cur;
    while (ri < n && cyc < 3000) begin
      @(negedge clk);
      snd = (bw < n) && (pace == 0 || (cyc % (pace + 1)) != 0) && (bb != 0 || lnk_ack_o);
      cur = gen(bw, s);
      lnk_clk_i = snd;
      lnk_din   = snd ? cur[bb*8 +: 8] : 8'h00;
      rx_ready  = (pace == 0) ? 1'b1 : ((cyc % 3) != 1);
      #1;
      if (rx_valid && rx_ready) begin
        chk(rx_word == (gen(ri, s) & msk(w)), "R2 received word", rx_word, gen(ri, s) & msk(w));
        ri++;
      end
      chk(!tx_ready && !lnk_clk_o, "R7 transmit side quiet in receive", 48'({tx_ready, lnk_clk_o}), 48'd0);
      if (snd) begin
        bb++;
        if (bb == nb) begin bb = 0; bw++; end
      end
      cyc++;
    end
    chk(ri == n, "R4 receive word count", 48'(ri), 48'(n));
    @(negedge clk);
    lnk_clk_i = 1'b0; rx_ready = 1'b0;
  endtask

  task automatic send_word(bit w, int k, int s);
    logic [47:0] v = gen(k, s);
    for (int j = 0; j < (w ? 6 : 4); j++) begin
      @(negedge clk);
      lnk_clk_i = 1'b0;
      if (j == 0) while (!lnk_ack_o) @(negedge clk);
      lnk_clk_i = 1'b1;
      lnk_din   = v[j*8 +: 8];
    end
    @(negedge clk);
    lnk_clk_i = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; dir_tx = 1'b0; wide = 1'b0;
    tx_word = '0; tx_valid = 1'b0; rx_ready = 1'b0;
    lnk_din = '0; lnk_clk_i = 1'b0; lnk_ack_i = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(!tx_ready && !rx_valid && !lnk_clk_o && !lnk_ack_o, "R9 reset state",
        48'({tx_ready, rx_valid, lnk_clk_o, lnk_ack_o}), 48'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int w = 0; w < 2; w++) begin
      setup(1'b1, w[0]);
      tx_run(w[0], 0, 5);
      tx_run(w[0], 1, 5);
      tx_run(w[0], 3, 4);
      setup(1'b0, w[0]);
      rx_run(w[0], 0, 5, 11);
      rx_run(w[0], 2, 5, 12);
      rx_run(w[0], 4, 4, 13);
    end

    // R3: both stores full drops ack and discards stray bytes
    setup(1'b0, 1'b0);
    send_word(1'b0, 0, 9);
    send_word(1'b0, 1, 9);
    #1;
    chk(!lnk_ack_o, "R3 ack low when both stores full", 48'(lnk_ack_o), 48'd0);
    chk(rx_valid && rx_word == (gen(0, 9) & msk(0)), "R3 first word held", rx_word, gen(0, 9) & msk(0));
    lnk_clk_i = 1'b1; lnk_din = 8'hFF;
    @(negedge clk);
    lnk_clk_i = 1'b0; rx_ready = 1'b1;
    #1;
    chk(rx_word == (gen(0, 9) & msk(0)), "R4 held word unchanged", rx_word, gen(0, 9) & msk(0));
    @(negedge clk);
    #1;
    chk(rx_valid && rx_word == (gen(1, 9) & msk(0)), "R3 second word moved up", rx_word, gen(1, 9) & msk(0));
    chk(lnk_ack_o, "R3 ack back high", 48'(lnk_ack_o), 48'd1);
    @(negedge clk);
    rx_ready = 1'b0;
    send_word(1'b0, 2, 9);
    #1;
    chk(rx_valid && rx_word == (gen(2, 9) & msk(0)), "R3 stray byte discarded", rx_word, gen(2, 9) & msk(0));

    // R8: mode inputs ignored while enabled
    setup(1'b1, 1'b0);
    @(negedge clk);
    dir_tx = 1'b0; wide = 1'b1;
    tx_run(1'b0, 0, 2);
    chk(!lnk_ack_o, "R8 still transmitter", 48'(lnk_ack_o), 48'd0);

    // R9: disable discards held and partial words
    setup(1'b0, 1'b1);
    send_word(1'b1, 0, 20);
    for (int j = 0; j < 2; j++) begin
      @(negedge clk);
      lnk_clk_i = 1'b1; lnk_din = 8'hC3;
    end
    @(negedge clk);
    lnk_clk_i = 1'b0;
    #1;
    chk(rx_valid, "R9 word held before disable", 48'(rx_valid), 48'd1);
    @(negedge clk);
    enable = 1'b0;
    #1;
    chk(!lnk_ack_o && !tx_ready, "R9 quiet while disabled", 48'({lnk_ack_o, tx_ready}), 48'd0);
    @(negedge clk);
    #1;
    chk(!rx_valid, "R9 holding store cleared", 48'(rx_valid), 48'd0);
    enable = 1'b1;
    rx_run(1'b1, 0, 2, 21);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule